// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller sits behind a single coin slot that reports a five-cent coin on one line and a ten-cent coin on another, each as a one-cycle pulse. It adds up the credit deposited and raises a release output once at least fifteen cents has come in. It gives no change. Any credit beyond fifteen cents is simply lost. Once the release is raised, it stays raised, and further coins have no effect until a synchronous reset returns the machine to zero credit.

The credit is held in four levels: 0, 5, 10 and 15 cents, encoded as 2'b00, 2'b01, 2'b10 and 2'b11. A parameter picks how the release output is produced. In the first style it is decoded from the full-credit level. In the second style, which is the default, a Mealy decision is made from the current level and the coin being accepted, and that decision is registered so the output carries no glitches. Both styles raise the output at the same clock edge: the edge that samples the deciding coin.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst` is sampled high at a rising edge, the credit returns to 0 cents and `releaseOpen` is 0 after that edge, whatever the coin inputs are; reset has priority over coins.
- R2: A sampled `coinFive` pulse (with `coinTen` low) raises the credit by one level (5 cents).
- R3: A sampled `coinTen` pulse raises the credit by two levels (10 cents).
- R4: Any sum of 15 cents or more saturates at the 15-cent level (5+10, 10+5 and 10+10 all give 15).
- R5: `coinFive` and `coinTen` sampled together count as a single ten-cent coin, so from 0 cents they leave 10 cents and do not release.
- R6: `releaseOpen` is 1 exactly while the credit is 15 cents; it rises after the rising edge that samples the deciding coin.
- R7: At 15 cents, coin inputs are ignored: `releaseOpen` stays 1 until reset.
- R8: Cycles with no coin leave the credit unchanged.
- R9: Both output styles (`REG_MEALY` = 0 and 1) give identical `releaseOpen` timing at the ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| coinFive | input | 1 | Five-cent coin pulse |
| coinTen | input | 1 | Ten-cent coin pulse |
| releaseOpen | output | 1 | Release command, high at 15 cents |

## Verification
The assertions assume that the coin lines are synchronous to `clk` and already reduced to clean pulses. They also assume that reset is applied before the first coin counts, so checks are disabled while `rst` is high. The bench drives every input one time unit after a rising edge and holds it for a full cycle, so the inputs always meet these assumptions. Within those limits it covers simultaneous coins, long idle gaps, coins that arrive at full credit, and reset that arrives together with a coin.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;
  localparam int CREDIT_W = 2;
  localparam int SUM_W    = CREDIT_W + 1;

  typedef enum logic [CREDIT_W-1:0] {
    CR_0C  = 2'b00,
    CR_5C  = 2'b01,
    CR_10C = 2'b10,
    CR_15C = 2'b11
  } credit_t;

  typedef struct packed {
    logic clear;
    logic addFive;
    logic addTen;
  } creditCmd_t;
endpackage

// File: rtl/coin_vend_datapath.sv
module coin_vend_datapath
  import coin_vend_pkg::*;
(
  input  logic       clk,
  input  creditCmd_t cmd,
  output credit_t    creditLvl
);
  localparam logic [SUM_W-1:0] FULL_SUM = SUM_W'(CR_15C);

  logic [SUM_W-1:0] stepSum;
  credit_t          creditNext;

  always_comb begin
    stepSum = {1'b0, creditLvl};
    if (cmd.addTen)       stepSum = stepSum + SUM_W'(2);
    else if (cmd.addFive) stepSum = stepSum + SUM_W'(1);
    if (cmd.clear)                 creditNext = CR_0C;
    else if (stepSum >= FULL_SUM)  creditNext = CR_15C;
    else                           creditNext = credit_t'(stepSum[CREDIT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    creditLvl <= creditNext;
  end
endmodule

// File: rtl/coin_vend_control.sv
module coin_vend_control
  import coin_vend_pkg::*;
#(
  parameter bit REG_MEALY = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       coinFive,
  input  logic       coinTen,
  input  credit_t    creditLvl,
  output creditCmd_t cmd,
  output logic       releaseOpen
);
  always_comb begin
    cmd.clear   = rst;
    cmd.addTen  = !rst && coinTen;
    cmd.addFive = !rst && coinFive && !coinTen;
  end

  generate
    if (REG_MEALY) begin : g_mealyReg
      logic reachFull;
      logic openQ;
      always_comb begin
        unique case (creditLvl)
          CR_15C:  reachFull = 1'b1;
          CR_10C:  reachFull = cmd.addFive || cmd.addTen;
          CR_5C:   reachFull = cmd.addTen;
          default: reachFull = 1'b0;
        endcase
      end
      always_ff @(posedge clk) begin
        if (rst) openQ <= 1'b0;
        else     openQ <= reachFull;
      end
      assign releaseOpen = openQ;
    end else begin : g_moore
      assign releaseOpen = (creditLvl == CR_15C);
    end
  endgenerate
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import coin_vend_pkg::*;
#(
  parameter bit REG_MEALY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic coinFive,
  input  logic coinTen,
  output logic releaseOpen
);
  creditCmd_t cmd;
  credit_t    creditLvl;

  coin_vend_control #(.REG_MEALY(REG_MEALY)) u_control (
    .clk        (clk),
    .rst        (rst),
    .coinFive   (coinFive),
    .coinTen    (coinTen),
    .creditLvl  (creditLvl),
    .cmd        (cmd),
    .releaseOpen(releaseOpen)
  );

  coin_vend_datapath u_datapath (
    .clk      (clk),
    .cmd      (cmd),
    .creditLvl(creditLvl)
  );
endmodule

// File: rtl/coin_vend_checker.sv
module coin_vend_checker (
  input logic       clk,
  input logic       rst,
  input logic       coinFive,
  input logic       coinTen,
  input logic [1:0] creditLvl,
  input logic       releaseOpen
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (creditLvl == 2'b00) && !releaseOpen);

  assert_nickel_step_R2: assert property (@(posedge clk) disable iff (rst)
    (creditLvl == 2'b00 && coinFive && !coinTen) |=> creditLvl == 2'b01);

  assert_dime_saturates_R4: assert property (@(posedge clk) disable iff (rst)
    (creditLvl == 2'b01 && coinTen) |=> creditLvl == 2'b11);

  assert_both_is_dime_R5: assert property (@(posedge clk) disable iff (rst)
    (creditLvl == 2'b00 && coinFive && coinTen) |=> creditLvl == 2'b10);

  assert_open_matches_full_R6: assert property (@(posedge clk) disable iff (rst)
    releaseOpen == (creditLvl == 2'b11));

  assert_full_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (creditLvl == 2'b11) |=> (creditLvl == 2'b11) && releaseOpen);

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!coinFive && !coinTen) |=> $stable(creditLvl));
endmodule

bind coin_vend_ctrl coin_vend_checker u_checker (
  .clk        (clk),
  .rst        (rst),
  .coinFive   (coinFive),
  .coinTen    (coinTen),
  .creditLvl  (creditLvl),
  .releaseOpen(releaseOpen)
);

// File: tb/coin_vend_ctrl_test.sv
`timescale 1ns/1ps
module coin_vend_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coinFive = 1'b0;
  logic coinTen = 1'b0;
  logic openMealy, openMoore;
  int   vectors = 0;
  int   miscompares = 0;
  int   modelCents = 0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  coin_vend_ctrl uut (
    .clk(clk), .rst(rst), .coinFive(coinFive), .coinTen(coinTen),
    .releaseOpen(openMealy)
  );

  coin_vend_ctrl #(.REG_MEALY(1'b0)) uutMoore (
    .clk(clk), .rst(rst), .coinFive(coinFive), .coinTen(coinTen),
    .releaseOpen(openMoore)
  );

  // Apply one cycle of stimulus, advance the behavioural model, and compare.
  task automatic cycle(input bit r, input bit n, input bit d, input string tag);
    bit expOpen;
    rst = r; coinFive = n; coinTen = d;
    @(posedge clk);
    if (r)                modelCents = 0;
    else if (modelCents < 15) begin
      if (d)      modelCents = modelCents + 10;
      else if (n) modelCents = modelCents + 5;
      if (modelCents > 15) modelCents = 15;
    end
    #1;
    expOpen = (modelCents >= 15);
    vectors++;
    if (openMealy !== expOpen) begin
      miscompares++;
      $display("FAIL %s registered-Mealy open: got %b expected %b", tag, openMealy, expOpen);
    end
    vectors++;
    if (openMoore !== expOpen) begin
      miscompares++;
      $display("FAIL %s R9 Moore open: got %b expected %b", tag, openMoore, expOpen);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    cycle(1, 0, 0, "R1 reset");
    cycle(1, 1, 1, "R1 reset with coins");
    // three nickels
    cycle(0, 1, 0, "R2 nickel 5");
    cycle(0, 1, 0, "R2 nickel 10");
    cycle(0, 1, 0, "R6 nickel reaches 15");
    cycle(0, 0, 0, "R6 open held");
    // dime then nickel
    cycle(1, 0, 0, "R1 clear");
    cycle(0, 0, 1, "R3 dime 10");
    cycle(0, 0, 0, "R8 idle at 10");
    cycle(0, 1, 0, "R4 10+5");
    // nickel then dime
    cycle(1, 0, 0, "R1 clear");
    cycle(0, 1, 0, "R2 nickel");
    cycle(0, 0, 1, "R4 5+10");
    // dime then dime
    cycle(1, 0, 0, "R1 clear");
    cycle(0, 0, 1, "R3 dime");
    cycle(0, 0, 1, "R4 10+10 saturates");
    // simultaneous coins
    cycle(1, 0, 0, "R1 clear");
    cycle(0, 1, 1, "R5 both coins from 0");
    cycle(0, 0, 0, "R5 no release at 10");
    cycle(0, 1, 0, "R5 nickel after both");
    // long idle gaps
    cycle(1, 0, 0, "R1 clear");
    for (int i = 0; i < 6; i++) cycle(0, 0, 0, "R8 idle at 0");
    cycle(0, 1, 0, "R8 nickel after idle");
    for (int i = 0; i < 5; i++) cycle(0, 0, 0, "R8 idle at 5");
    cycle(0, 1, 0, "R8 second nickel");
    cycle(0, 0, 0, "R8 still 10");
    cycle(0, 1, 0, "R6 third nickel opens");
    // coins at full credit
    cycle(0, 1, 0, "R7 nickel at 15");
    cycle(0, 0, 1, "R7 dime at 15");
    cycle(0, 1, 1, "R7 both at 15");
    cycle(0, 0, 0, "R7 idle at 15");
    // reset wins over a coin
    cycle(1, 0, 1, "R1 reset with dime");
    cycle(0, 0, 0, "R1 after reset");
    cycle(0, 1, 0, "R2 nickel after reset");
    cycle(1, 0, 1, "R1 reset at 5 with dime");
    cycle(0, 0, 1, "R3 dime from 0");
    cycle(0, 0, 0, "R8 idle at 10");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule